// File: doc/BRIEF.md
# Capture Record Stream Deframer

This block sits on the consuming side of a capture pipeline. Bytes arrive one per valid/ready handshake and form a series of records. A record that opens with the marker byte 0xA0 is a packet record: an 8-byte header, then a payload. A record that opens with any other byte is a 2-byte filler and is thrown away. For each packet record the block decodes the header and emits the payload as a byte stream with start and end markers. The decoded flags, the original length, the captured length and an extended timestamp travel beside every beat.

A session gate decides which packets leave the block. A packet that carries the session-start flag opens the gate. A packet that carries the session-end flag still leaves the block, and then the gate closes. Payload bytes of packets outside a session are consumed and dropped. The raw 24-bit timestamp counts 60 MHz ticks. It is widened by an offset that grows by 2^24 each time a header's timestamp is smaller than the one before it. A single-cycle error pulse marks headers with unusual flag combinations.

Back-pressure rules: the output holds `out_valid` and its data while `out_ready` is low, and the block takes no input byte during that time. Header bytes and dropped payload bytes are taken whenever `in_valid` is high. `in_ready` never depends on `in_valid`. The sideband fields are meaningful while `out_valid` is high.

Top module: `cap_deframer`

## Requirements
- R1: A record whose first byte is 0xA0 is a packet record with an 8-byte header (marker included). A record with any other first byte is exactly 2 bytes long and produces no output, even when its second byte is 0xA0.
- R2: Header byte 1 is the low byte and byte 2 the high byte of the 16-bit flags, shown on `out_flags`. Bytes 3 and 4 (low first) form the original length, shown on `out_orig_len`. Payload bytes leave on `out_data` in arrival order.
- R3: When flag bit 3 (0x0008, truncated) is set, the payload is exactly 1027 bytes, whatever the length field holds. Otherwise the payload length equals the length field. `out_cap_len` reports the payload length used.
- R4: The first payload beat carries `out_sop` and the last carries `out_eop`. A forwarded packet with a zero-length payload produces one beat with `out_sop`, `out_eop` and `out_empty` all high.
- R5: Flag bit 4 (0x0010) opens the session before that packet is judged. Packets are forwarded only while the session is open. Flag bit 5 (0x0020) forwards its packet and then closes the session. Payload bytes outside a session are consumed and dropped.
- R6: `err_pulse` is high for exactly one cycle per packet record whose flags are non-zero and not exactly 0x0010 and not exactly 0x0020. It stays low for all other records.
- R7: Header bytes 5..7 hold a 24-bit timestamp, least significant byte first. When it is smaller than the previous packet record's timestamp (every packet record counts, forwarded or not), the offset grows by 0x1000000. `out_ts` is the offset plus the raw timestamp.
- R8: While a forwarded beat is stalled by `out_ready` low, no input byte is consumed. No payload byte is lost or duplicated under any stall pattern.
- R9: After synchronous reset the block waits for a record start with `in_ready` high and `out_valid` low. The session is closed and the timestamp offset is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input record byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_empty | output | 1 | Beat carries no payload byte (zero-length packet) |
| out_flags | output | 16 | Decoded header flags |
| out_orig_len | output | 16 | Original length field from the header |
| out_cap_len | output | 16 | Payload bytes actually carried |
| out_ts | output | 32 | Extended timestamp |
| err_pulse | output | 1 | One-cycle pulse for an unusual flags word |

## Verification
Filler records whose second byte is the marker value are mixed with packet records, so that a framing slip appears as extra or shifted beats. Flag sequences cover a packet before any session, a start/middle/end series, a packet after the close and a combined start-and-end packet, which separate gating mistakes from error-pulse mistakes. Truncated packets with length fields both above and below 1027, plus a zero-length packet, show that the payload count follows the flag and not the field. A timestamp that steps backwards and a pseudo-random stall pattern on `out_ready` expose a missing offset step and any lost or repeated byte.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int BYTE_W    = 8;
  localparam int FLAG_W    = 16;
  localparam int LEN_W     = 16;
  localparam int RAW_TS_W  = 24;
  localparam int HDR_BYTES = 8;
  localparam int IDX_W     = $clog2(HDR_BYTES);

  localparam logic [BYTE_W-1:0] REC_MARK = 8'hA0;

  localparam int FL_TRUNC = 3;
  localparam int FL_FIRST = 4;
  localparam int FL_LAST  = 5;

  typedef enum logic [2:0] {
    ST_LEAD,
    ST_SKIP,
    ST_HDR,
    ST_DECIDE,
    ST_PAY,
    ST_NULL
  } rx_state_e;
endpackage

// File: rtl/cdf_hdr_regs.sv
module cdf_hdr_regs
  import cdf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_we,
  input  logic [IDX_W-1:0]    byte_idx,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [FLAG_W-1:0]   flags,
  output logic [LEN_W-1:0]    orig_len,
  output logic [RAW_TS_W-1:0] raw_ts
);
  localparam int LAST_IDX = HDR_BYTES - 1;

  logic [BYTE_W-1:0] hb [1:LAST_IDX];

  for (genvar g = 1; g <= LAST_IDX; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        hb[g] <= '0;
      end else if (byte_we && byte_idx == IDX_W'(g)) begin
        hb[g] <= byte_in;
      end
    end
  end

  assign flags    = {hb[2], hb[1]};
  assign orig_len = {hb[4], hb[3]};
  assign raw_ts   = {hb[7], hb[6], hb[5]};
endmodule

// File: rtl/cdf_session.sv
module cdf_session
  import cdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              decide,
  input  logic [FLAG_W-1:0] flags,
  output logic              fwd,
  output logic              err_pulse
);
  localparam logic [FLAG_W-1:0] ONLY_FIRST = FLAG_W'(1) << FL_FIRST;
  localparam logic [FLAG_W-1:0] ONLY_LAST  = FLAG_W'(1) << FL_LAST;

  logic open_q;
  logic is_first, is_last;

  assign is_first = flags[FL_FIRST];
  assign is_last  = flags[FL_LAST];
  assign fwd      = open_q | is_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (decide) begin
      open_q <= fwd & ~is_last;
    end
  end

  assign err_pulse = decide && (flags != '0) &&
                     (flags != ONLY_FIRST) && (flags != ONLY_LAST);

  assert_session_close_R5: assert property (@(posedge clk) disable iff (rst)
    (decide && is_last) |=> !open_q);

  assert_session_open_R5: assert property (@(posedge clk) disable iff (rst)
    (decide && is_first && !is_last) |=> open_q);

  assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);
endmodule

// File: rtl/cdf_ts_ext.sv
module cdf_ts_ext
  import cdf_pkg::*;
#(
  parameter int EXT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [RAW_TS_W-1:0] raw,
  output logic [EXT_W-1:0]    ext_ts
);
  localparam logic [EXT_W-1:0] STEP = EXT_W'(1) << RAW_TS_W;

  logic [RAW_TS_W-1:0] prev_q;
  logic [EXT_W-1:0]    off_q, off_n;

  assign off_n = (raw < prev_q) ? off_q + STEP : off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      off_q  <= '0;
      ext_ts <= '0;
    end else if (load) begin
      prev_q <= raw;
      off_q  <= off_n;
      ext_ts <= off_n + EXT_W'(raw);
    end
  end

  assert_ts_low_bits_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> ext_ts[RAW_TS_W-1:0] == $past(raw));

  assert_ts_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ext_ts));
endmodule

// File: rtl/cdf_rec_fsm.sv
module cdf_rec_fsm
  import cdf_pkg::*;
#(
  parameter int MAX_CAP = 1027
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_empty,
  output logic              hdr_we,
  output logic [IDX_W-1:0]  hdr_idx,
  output logic              decide,
  input  logic              trunc,
  input  logic [LEN_W-1:0]  orig_len,
  input  logic              fwd,
  output logic [LEN_W-1:0]  cap_len
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] CAP_MAX = LEN_W'(MAX_CAP);

  rx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] remain_q;
  logic [LEN_W-1:0] cap_sel;
  logic             fwd_q;
  logic             lead_q;
  logic             take;

  assign cap_sel = trunc ? CAP_MAX : orig_len;
  assign hdr_idx = idx_q;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    out_empty = 1'b0;
    out_data  = '0;
    hdr_we    = 1'b0;
    decide    = 1'b0;
    unique case (state_q)
      ST_LEAD, ST_SKIP: in_ready = 1'b1;
      ST_HDR: begin
        in_ready = 1'b1;
        hdr_we   = in_valid;
      end
      ST_DECIDE: decide = 1'b1;
      ST_PAY: begin
        in_ready  = fwd_q ? out_ready : 1'b1;
        out_valid = fwd_q & in_valid;
        out_data  = in_data;
        out_sop   = lead_q;
        out_eop   = (remain_q == LEN_W'(1));
      end
      ST_NULL: begin
        out_valid = 1'b1;
        out_sop   = 1'b1;
        out_eop   = 1'b1;
        out_empty = 1'b1;
      end
      default: ;
    endcase
  end

  assign take = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_LEAD;
      idx_q    <= '0;
      remain_q <= '0;
      cap_len  <= '0;
      fwd_q    <= 1'b0;
      lead_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LEAD: if (take) begin
          idx_q   <= IDX_W'(1);
          state_q <= (in_data == REC_MARK) ? ST_HDR : ST_SKIP;
        end
        ST_SKIP: if (take) state_q <= ST_LEAD;
        ST_HDR: if (take) begin
          if (idx_q == IDX_END) state_q <= ST_DECIDE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        ST_DECIDE: begin
          cap_len  <= cap_sel;
          remain_q <= cap_sel;
          fwd_q    <= fwd;
          lead_q   <= 1'b1;
          if (cap_sel == '0) state_q <= fwd ? ST_NULL : ST_LEAD;
          else state_q <= ST_PAY;
        end
        ST_PAY: if (take) begin
          remain_q <= remain_q - LEN_W'(1);
          lead_q   <= 1'b0;
          if (remain_q == LEN_W'(1)) state_q <= ST_LEAD;
        end
        ST_NULL: if (out_ready) state_q <= ST_LEAD;
        default: state_q <= ST_LEAD;
      endcase
    end
  end

  assert_stall_no_take_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !(in_valid && in_ready));

  assert_gap_after_eop_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eop) |=> !out_valid);

  assert_skip_no_hdr_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LEAD && in_valid && in_data != REC_MARK) |=> !hdr_we);
endmodule

// File: rtl/cap_deframer.sv
module cap_deframer
  import cdf_pkg::*;
#(
  parameter int MAX_CAP = 1027,
  parameter int EXT_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_empty,
  output logic [FLAG_W-1:0] out_flags,
  output logic [LEN_W-1:0]  out_orig_len,
  output logic [LEN_W-1:0]  out_cap_len,
  output logic [EXT_W-1:0]  out_ts,
  output logic              err_pulse
);
  logic                hdr_we;
  logic [IDX_W-1:0]    hdr_idx;
  logic                decide;
  logic                fwd;
  logic [RAW_TS_W-1:0] raw_ts;

  cdf_rec_fsm #(.MAX_CAP(MAX_CAP)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_empty (out_empty),
    .hdr_we    (hdr_we),
    .hdr_idx   (hdr_idx),
    .decide    (decide),
    .trunc     (out_flags[FL_TRUNC]),
    .orig_len  (out_orig_len),
    .fwd       (fwd),
    .cap_len   (out_cap_len)
  );

  cdf_hdr_regs u_hdr (
    .clk      (clk),
    .rst      (rst),
    .byte_we  (hdr_we),
    .byte_idx (hdr_idx),
    .byte_in  (in_data),
    .flags    (out_flags),
    .orig_len (out_orig_len),
    .raw_ts   (raw_ts)
  );

  cdf_session u_sess (
    .clk       (clk),
    .rst       (rst),
    .decide    (decide),
    .flags     (out_flags),
    .fwd       (fwd),
    .err_pulse (err_pulse)
  );

  cdf_ts_ext #(.EXT_W(EXT_W)) u_ts (
    .clk    (clk),
    .rst    (rst),
    .load   (decide),
    .raw    (raw_ts),
    .ext_ts (out_ts)
  );

  assert_trunc_len_R3: assert property (@(posedge clk) disable iff (rst)
    (decide && out_flags[FL_TRUNC]) |=> out_cap_len == LEN_W'(MAX_CAP));

  assert_plain_len_R3: assert property (@(posedge clk) disable iff (rst)
    (decide && !out_flags[FL_TRUNC]) |=> out_cap_len == $past(out_orig_len));
endmodule

// File: tb/cap_deframer_tb.sv
module cap_deframer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        out_sop, out_eop, out_empty;
  logic [15:0] out_flags, out_orig_len, out_cap_len;
  logic [31:0] out_ts;
  logic        err_pulse;

  always #4 clk = ~clk;

  cap_deframer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty),
    .out_flags(out_flags), .out_orig_len(out_orig_len), .out_cap_len(out_cap_len),
    .out_ts(out_ts), .err_pulse(err_pulse)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  logic [7:0]  mb_data  [0:4095];
  bit          mb_sop   [0:4095];
  bit          mb_eop   [0:4095];
  bit          mb_empty [0:4095];
  logic [15:0] mp_flags [0:63];
  logic [15:0] mp_orig  [0:63];
  logic [15:0] mp_cap   [0:63];
  logic [31:0] mp_ts    [0:63];
  int n_beats = 0, n_pkts = 0, n_err = 0, n_stall = 0, n_leak = 0;

  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (n_beats < 4096) begin
          mb_data[n_beats]  = out_data;
          mb_sop[n_beats]   = out_sop;
          mb_eop[n_beats]   = out_eop;
          mb_empty[n_beats] = out_empty;
        end
        if (out_sop && n_pkts < 64) begin
          mp_flags[n_pkts] = out_flags;
          mp_orig[n_pkts]  = out_orig_len;
          mp_cap[n_pkts]   = out_cap_len;
          mp_ts[n_pkts]    = out_ts;
        end
        if (out_sop) n_pkts++;
        n_beats++;
      end
      if (out_valid && !out_ready) begin
        n_stall++;
        if (in_valid && in_ready) n_leak++;
      end
      if (err_pulse) n_err++;
    end
  end

  // out_ready driver
  bit bp_mode = 0;
  logic [7:0] lf = 8'h5a;
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (bp_mode) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        out_ready = lf[0];
      end else begin
        out_ready = 1'b1;
      end
    end
  end

  // reference timestamp model
  logic [23:0] r_prev = '0;
  logic [31:0] r_off  = '0;
  task automatic ref_ts(input logic [23:0] raw, output logic [31:0] ext);
    if (raw < r_prev) r_off = r_off + 32'h0100_0000;
    r_prev = raw;
    ext = r_off + {8'h00, raw};
  endtask

  // called at posedge+1
  task automatic send_byte(input logic [7:0] b);
    bit rdy;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk); #1;
      if (rdy) break;
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(input logic [15:0] fl, input logic [15:0] len, input logic [23:0] ts,
                          input int npay, input logic [7:0] seed, output logic [31:0] ext);
    send_byte(8'hA0);
    send_byte(fl[7:0]);   send_byte(fl[15:8]);
    send_byte(len[7:0]);  send_byte(len[15:8]);
    send_byte(ts[7:0]);   send_byte(ts[15:8]);  send_byte(ts[23:16]);
    for (int i = 0; i < npay; i++) send_byte(8'(seed + i));
    ref_ts(ts, ext);
  endtask

  task automatic check_pkt(input int pi, input int bi, input logic [15:0] fl,
                           input logic [15:0] orig, input int cap, input logic [31:0] ts,
                           input logic [7:0] seed);
    chk(mp_flags[pi] == fl,   "R2 flags field",    mp_flags[pi], fl);
    chk(mp_orig[pi] == orig,  "R2 length field",   mp_orig[pi], orig);
    chk(mp_cap[pi] == 16'(cap), "R3 captured length", mp_cap[pi], cap);
    chk(mp_ts[pi] == ts,      "R7 extended timestamp", mp_ts[pi], ts);
    if (cap == 0) begin
      chk(mb_empty[bi] && mb_sop[bi] && mb_eop[bi], "R4 empty beat markers",
          {mb_empty[bi], mb_sop[bi], mb_eop[bi]}, 3'b111);
    end else begin
      for (int i = 0; i < cap; i++) begin
        chk(mb_data[bi+i] == 8'(seed + i), "R8 payload byte order", mb_data[bi+i], 8'(seed + i));
        chk(mb_sop[bi+i] == (i == 0), "R4 sop marker", mb_sop[bi+i], i == 0);
        chk(mb_eop[bi+i] == (i == cap - 1), "R4 eop marker", mb_eop[bi+i], i == cap - 1);
      end
    end
  endtask

  task automatic t_reset;
    in_valid = 1'b0; in_data = '0; rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1,  "R9 in_ready after reset",  in_ready, 1);
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    chk(err_pulse == 1'b0, "R9 err low after reset",   err_pulse, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_skip;
    int pb = n_pkts, bb = n_beats, eb = n_err;
    logic [31:0] e;
    send_byte(8'h12); send_byte(8'hA0);
    send_byte(8'h55); send_byte(8'h01);
    send_pkt(16'h0030, 16'd2, 24'h000010, 2, 8'h40, e);
    idle(6);
    chk(n_pkts - pb == 1,  "R1 filler records skipped, packet count", n_pkts - pb, 1);
    chk(n_beats - bb == 2, "R1 beat count", n_beats - bb, 2);
    check_pkt(pb, bb, 16'h0030, 16'd2, 2, e, 8'h40);
    chk(mp_ts[pb] == 32'h10, "R9 offset zero after reset", mp_ts[pb], 32'h10);
    chk(n_err - eb == 1, "R6 pulse for first|last flags", n_err - eb, 1);
  endtask

  task automatic t_session;
    int pb = n_pkts, bb = n_beats, eb = n_err;
    logic [31:0] ea, eb2, ec, ed, ee;
    send_pkt(16'h0000, 16'd2, 24'h000100, 2, 8'h00, ea);
    send_pkt(16'h0010, 16'd3, 24'h000200, 3, 8'h10, eb2);
    send_pkt(16'h0000, 16'd2, 24'h000300, 2, 8'h20, ec);
    send_pkt(16'h0020, 16'd1, 24'h000400, 1, 8'h30, ed);
    send_pkt(16'h0000, 16'd2, 24'h000500, 2, 8'h50, ee);
    idle(6);
    chk(n_pkts - pb == 3,  "R5 only in-session packets forwarded", n_pkts - pb, 3);
    chk(n_beats - bb == 6, "R5 beat count", n_beats - bb, 6);
    check_pkt(pb,     bb,     16'h0010, 16'd3, 3, eb2, 8'h10);
    check_pkt(pb + 1, bb + 3, 16'h0000, 16'd2, 2, ec,  8'h20);
    check_pkt(pb + 2, bb + 5, 16'h0020, 16'd1, 1, ed,  8'h30);
    chk(n_err - eb == 0, "R6 no pulse for plain flags", n_err - eb, 0);
  endtask

  task automatic t_trunc;
    int pb = n_pkts, bb = n_beats, eb = n_err;
    logic [31:0] e0, e1, e2;
    send_pkt(16'h0010, 16'd0,    24'h001000, 0,    8'h00, e0);
    send_pkt(16'h0008, 16'd2000, 24'h002000, 1027, 8'h33, e1);
    send_pkt(16'h0028, 16'd4,    24'h003000, 1027, 8'h77, e2);
    idle(6);
    chk(n_pkts - pb == 3, "R3 packet count", n_pkts - pb, 3);
    chk(n_beats - bb == 1 + 2 * 1027, "R3 beat count", n_beats - bb, 1 + 2 * 1027);
    check_pkt(pb,     bb,            16'h0010, 16'd0,    0,    e0, 8'h00);
    check_pkt(pb + 1, bb + 1,        16'h0008, 16'd2000, 1027, e1, 8'h33);
    check_pkt(pb + 2, bb + 1 + 1027, 16'h0028, 16'd4,    1027, e2, 8'h77);
    chk(n_err - eb == 2, "R6 pulses for truncated records", n_err - eb, 2);
  endtask

  task automatic t_ts;
    int pb = n_pkts, bb = n_beats;
    logic [31:0] e0, e1;
    send_pkt(16'h0010, 16'd1, 24'hFFFFF0, 1, 8'h90, e0);
    send_pkt(16'h0020, 16'd1, 24'h000010, 1, 8'h91, e1);
    idle(6);
    chk(n_pkts - pb == 2, "R7 packet count", n_pkts - pb, 2);
    check_pkt(pb,     bb,     16'h0010, 16'd1, 1, e0, 8'h90);
    check_pkt(pb + 1, bb + 1, 16'h0020, 16'd1, 1, e1, 8'h91);
    chk(mp_ts[pb] == 32'h00FFFFF0,     "R7 no step before wrap", mp_ts[pb], 32'h00FFFFF0);
    chk(mp_ts[pb + 1] == 32'h01000010, "R7 step after wrap", mp_ts[pb + 1], 32'h01000010);
  endtask

  task automatic t_bp;
    int pb = n_pkts, bb = n_beats, sb = n_stall, lb = n_leak;
    logic [31:0] e0, e1;
    bp_mode = 1;
    send_pkt(16'h0010, 16'd20, 24'h000100, 20, 8'hC0, e0);
    send_pkt(16'h0020, 16'd7,  24'h000200, 7,  8'hE0, e1);
    idle(6);
    bp_mode = 0;
    idle(2);
    chk(n_pkts - pb == 2,   "R8 packet count under stalls", n_pkts - pb, 2);
    chk(n_beats - bb == 27, "R8 no lost or repeated beats", n_beats - bb, 27);
    check_pkt(pb,     bb,      16'h0010, 16'd20, 20, e0, 8'hC0);
    check_pkt(pb + 1, bb + 20, 16'h0020, 16'd7,  7,  e1, 8'hE0);
    chk(n_stall - sb > 0,   "R8 stalls exercised", n_stall - sb, 1);
    chk(n_leak - lb == 0,   "R8 no input taken while stalled", n_leak - lb, 0);
  endtask

  task automatic t_err;
    int pb = n_pkts, bb = n_beats, eb = n_err;
    logic [31:0] e0, e1, e2;
    send_pkt(16'h0001, 16'd1, 24'h000300, 1, 8'hA0, e0);
    idle(4);
    chk(n_err - eb == 1,  "R6 pulse for phy error flag", n_err - eb, 1);
    chk(n_pkts - pb == 0, "R5 closed session drops packet", n_pkts - pb, 0);
    send_pkt(16'h0010, 16'd1, 24'h000400, 1, 8'h05, e1);
    send_pkt(16'h0020, 16'd0, 24'h000500, 0, 8'h00, e2);
    idle(6);
    chk(n_err - eb == 1,  "R6 no pulse for exact first/last", n_err - eb, 1);
    chk(n_pkts - pb == 2, "R4 zero-length last packet forwarded", n_pkts - pb, 2);
    check_pkt(pb,     bb,     16'h0010, 16'd1, 1, e1, 8'h05);
    check_pkt(pb + 1, bb + 1, 16'h0020, 16'd0, 0, e2, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_skip();
    t_session();
    t_trunc();
    t_ts();
    t_bp();
    t_err();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule